// File: doc/BRIEF.md
# Ping-Pong Receive DMA Status Tracker

This block keeps the status word for a DMA engine that moves received bytes into two alternating memory buffers, A and B. Software loads a buffer with a length. The engine then pops bytes from a receive FIFO into whichever buffer is next in line. Each popped byte carries three error tags: frame, parity and overrun. The block records each tag as a sticky bit that belongs to the buffer that drained the byte. A sticky bit clears only when that same buffer is reloaded, or when the receive side is reset.

A second sequencer of the same kind runs the transmit side. It reports which transmit buffers still hold bytes to send.

In SPI slave mode the block watches the active-low slave-select line. On the first deassertion after a clear, it saves the byte count of the buffer that is filling and records which buffer that was. Any later deassertion only marks that the line went high more than once. The status word is read-only and combinational from internal state.

Top module: `rxdma_stat_tracker`

## Requirements
- R1: After reset, `status_o` and `saved_cnt_o` read zero and both pop outputs are low. Status bits 15:13 always read zero.
- R2: Status bit layout: [2:0] slave-select code, [3] receive A active, [4] receive B active, [5] transmit A active, [6] transmit B active, [7]/[8] frame error A/B, [9]/[10] parity error A/B, [11]/[12] overrun A/B.
- R3: Receive buffers fill strictly A, B, A, and so on. `rx_pop_o` is high only while the next-in-line buffer is active and is not being loaded in that cycle. A buffer goes inactive once it has taken its loaded length. A load with length zero leaves the buffer inactive.
- R4: In UART mode (`spi_mode_i`=0), a popped byte tagged with a frame error sets the frame bit of the buffer that took it.
- R5: In UART mode, a popped byte tagged with a parity error sets the parity bit of the buffer that took it.
- R6: An overrun tag is charged to the buffer that drains the tagged byte. While neither buffer is loaded, no byte is popped and no overrun bit is set.
- R7: Loading a receive buffer clears that buffer's frame, parity and overrun bits and leaves the other buffer's bits unchanged.
- R8: `dma_rst_i` clears all receive status bits and the saved count, and points the sequencer back at buffer A. Transmit bits are not affected.
- R9: In SPI slave mode, frame and parity tags are ignored.
- R10: In SPI slave mode, the first rising edge of `ssel_n_i` after a clear sets the code to 2 (buffer A) or 3 (buffer B) and saves that buffer's current byte count. Codes 1, 4 and 5 never appear.
- R11: A further rising edge before a clear sets code bit 2, giving 6 or 7, and leaves the saved count unchanged.
- R12: The code clears on any receive-buffer load and on `dma_rst_i`. A rising edge of `ssel_n_i` in UART mode has no effect.
- R13: Transmit buffers follow the same alternating discipline. `tx_pop_o` drains A and then B, and each transmit-active bit falls when its buffer has sent its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_rst_i | input | 1 | Synchronous receive-side DMA reset |
| spi_mode_i | input | 1 | 1 = SPI slave mode, 0 = UART mode |
| rx_load_a_i | input | 1 | Load receive buffer A with `rx_len_i` |
| rx_load_b_i | input | 1 | Load receive buffer B with `rx_len_i` |
| rx_len_i | input | CNT_W | Receive buffer length for a load |
| rx_valid_i | input | 1 | Receive FIFO holds a byte |
| rx_frm_err_i | input | 1 | Head byte carries a frame error |
| rx_par_err_i | input | 1 | Head byte carries a parity error |
| rx_ovr_i | input | 1 | Head byte carries an overrun |
| rx_pop_o | output | 1 | Byte taken from the FIFO this cycle |
| ssel_n_i | input | 1 | Active-low slave select |
| tx_load_a_i | input | 1 | Load transmit buffer A with `tx_len_i` |
| tx_load_b_i | input | 1 | Load transmit buffer B with `tx_len_i` |
| tx_len_i | input | CNT_W | Transmit buffer length for a load |
| tx_req_i | input | 1 | Transmitter can accept a byte |
| tx_pop_o | output | 1 | Byte sent from a transmit buffer this cycle |
| status_o | output | 16 | Read-only status word |
| saved_cnt_o | output | CNT_W | Byte count saved on slave-select deassertion |

## Verification
The receive path is driven with single-tag bytes into A and then B. This shows whether a flag lands on the draining buffer or on a fixed one. Overrun-tagged bytes are offered while both buffers are unloaded, and then again in the same cycle as a reload. This separates "charged at overrun" from "charged when drained" and tests the load/pop interlock. A reload of A with B's flags still set shows whether clearing is per buffer. Slave-select pulses are applied once, then twice, then after a reload, with the other buffer filling, and then in UART mode. These patterns tell apart the single, multiple, buffer-select and ignored cases.

// File: rtl/rxdma_stat_pkg.sv
package rxdma_stat_pkg;

    localparam int NBUF   = 2;
    localparam int STAT_W = 16;

    // status word bit positions
    localparam int POS_SSEL  = 0;   // [2:0]
    localparam int POS_RXACT = 3;   // [4:3]
    localparam int POS_TXACT = 5;   // [6:5]
    localparam int POS_FRM   = 7;   // [8:7]
    localparam int POS_PAR   = 9;   // [10:9]
    localparam int POS_OVF   = 11;  // [12:11]

    localparam logic [STAT_W-1:0] RX_MASK = 16'h1F9F;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;

    typedef struct packed {
        logic frm;
        logic par;
        logic ovf;
    } buf_err_t;

endpackage

// File: rtl/pingpong_seq.sv
module pingpong_seq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [1:0]       load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             req_i,
    output logic             xfer_o,
    output logic             ptr_o,
    output logic [1:0]       act_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int NB = rxdma_stat_pkg::NBUF;

    typedef struct packed {
        logic [NB-1:0]            act;
        logic                     ptr;
        logic [NB-1:0][CNT_W-1:0] cnt;
        logic [NB-1:0][CNT_W-1:0] len;
    } seq_t;

    seq_t             s_d, s_q;
    logic [CNT_W-1:0] nxt_cnt;

    always_comb begin
        s_d     = s_q;
        xfer_o  = 1'b0;
        nxt_cnt = s_q.cnt[s_q.ptr] + CNT_W'(1);
        if (clr_i) begin
            s_d = '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (load_i[b]) begin
                    s_d.len[b] = len_i;
                    s_d.cnt[b] = '0;
                    s_d.act[b] = (len_i != '0);
                end
            end
            if (req_i && s_q.act[s_q.ptr] && !load_i[s_q.ptr]) begin
                xfer_o             = 1'b1;
                s_d.cnt[s_q.ptr]   = nxt_cnt;
                if (nxt_cnt == s_q.len[s_q.ptr]) begin
                    s_d.act[s_q.ptr] = 1'b0;
                    s_d.ptr          = ~s_q.ptr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr_o = s_q.ptr;
    assign act_o = s_q.act;
    assign cnt_o = s_q.cnt[s_q.ptr];

    for (genvar gb = 0; gb < NB; gb++) begin : g_bound
        // an active buffer never holds its full length
        assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.act[gb] |-> (s_q.cnt[gb] < s_q.len[gb]));
    end

endmodule

// File: rtl/rx_err_track.sv
module rx_err_track
    import rxdma_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [1:0]          load_i,
    input  logic                take_i,
    input  logic                ptr_i,
    input  logic                uart_i,
    input  logic                frm_i,
    input  logic                par_i,
    input  logic                ovr_i,
    output buf_err_t [NBUF-1:0] err_o
);
    buf_err_t [NBUF-1:0] e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (clr_i) begin
            e_d = '0;
        end else begin
            for (int b = 0; b < NBUF; b++) begin
                if (load_i[b]) e_d[b] = '0;
            end
            if (take_i) begin
                e_d[ptr_i].frm = e_q[ptr_i].frm | (frm_i & uart_i);
                e_d[ptr_i].par = e_q[ptr_i].par | (par_i & uart_i);
                e_d[ptr_i].ovf = e_q[ptr_i].ovf | ovr_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign err_o = e_q;

    for (genvar gb = 0; gb < NBUF; gb++) begin : g_chk
        assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            load_i[gb] |=> (err_o[gb] == '0));
        assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!take_i && !clr_i && !load_i[gb]) |=> $stable(err_o[gb]));
    end

endmodule

// File: rtl/ssel_capture.sv
module ssel_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_any_i,
    input  logic             spi_i,
    input  logic             ssel_n_i,
    input  logic             ptr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [2:0]       code_o,
    output logic [CNT_W-1:0] saved_o
);
    typedef struct packed {
        logic             prev;
        logic [2:0]       code;
        logic [CNT_W-1:0] saved;
    } cap_t;

    localparam cap_t CAP_RST = '{prev: 1'b1, code: 3'd0, saved: '0};

    cap_t cap_d, cap_q;
    logic rise;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = ssel_n_i;
        rise       = spi_i && ssel_n_i && !cap_q.prev;
        if (clr_i) begin
            cap_d.code  = 3'd0;
            cap_d.saved = '0;
        end else if (load_any_i) begin
            cap_d.code = 3'd0;
        end else if (rise) begin
            if (cap_q.code == 3'd0) begin
                cap_d.code  = {2'b01, ptr_i};
                cap_d.saved = cnt_i;
            end else begin
                cap_d.code[2] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= CAP_RST;
        else        cap_q <= cap_d;
    end

    assign code_o  = cap_q.code;
    assign saved_o = cap_q.saved;

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_o inside {3'd1, 3'd4, 3'd5}));
    assert_clear_on_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || load_any_i) |=> (code_o == 3'd0));
    assert_saved_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != 3'd0 && !clr_i) |=> $stable(saved_o));

endmodule

// File: rtl/rxdma_stat_tracker.sv
module rxdma_stat_tracker
    import rxdma_stat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_rst_i,
    input  logic              spi_mode_i,
    input  logic              rx_load_a_i,
    input  logic              rx_load_b_i,
    input  logic [CNT_W-1:0]  rx_len_i,
    input  logic              rx_valid_i,
    input  logic              rx_frm_err_i,
    input  logic              rx_par_err_i,
    input  logic              rx_ovr_i,
    output logic              rx_pop_o,
    input  logic              ssel_n_i,
    input  logic              tx_load_a_i,
    input  logic              tx_load_b_i,
    input  logic [CNT_W-1:0]  tx_len_i,
    input  logic              tx_req_i,
    output logic              tx_pop_o,
    output logic [STAT_W-1:0] status_o,
    output logic [CNT_W-1:0]  saved_cnt_o
);
    logic [1:0]          rx_load, tx_load, rx_act, tx_act;
    logic                rx_ptr, tx_ptr;
    logic [CNT_W-1:0]    rx_cnt, tx_cnt;
    logic [2:0]          ssel_code;
    buf_err_t [NBUF-1:0] err;

    assign rx_load = {rx_load_b_i, rx_load_a_i};
    assign tx_load = {tx_load_b_i, tx_load_a_i};

    pingpong_seq #(.CNT_W(CNT_W)) u_rx_seq (
        .clk(clk), .rst_n(rst_n), .clr_i(dma_rst_i), .load_i(rx_load),
        .len_i(rx_len_i), .req_i(rx_valid_i), .xfer_o(rx_pop_o),
        .ptr_o(rx_ptr), .act_o(rx_act), .cnt_o(rx_cnt)
    );

    pingpong_seq #(.CNT_W(CNT_W)) u_tx_seq (
        .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .load_i(tx_load),
        .len_i(tx_len_i), .req_i(tx_req_i), .xfer_o(tx_pop_o),
        .ptr_o(tx_ptr), .act_o(tx_act), .cnt_o(tx_cnt)
    );

    rx_err_track u_err (
        .clk(clk), .rst_n(rst_n), .clr_i(dma_rst_i), .load_i(rx_load),
        .take_i(rx_pop_o), .ptr_i(rx_ptr), .uart_i(!spi_mode_i),
        .frm_i(rx_frm_err_i), .par_i(rx_par_err_i), .ovr_i(rx_ovr_i),
        .err_o(err)
    );

    ssel_capture #(.CNT_W(CNT_W)) u_ssel (
        .clk(clk), .rst_n(rst_n), .clr_i(dma_rst_i),
        .load_any_i(|rx_load), .spi_i(spi_mode_i), .ssel_n_i(ssel_n_i),
        .ptr_i(rx_ptr), .cnt_i(rx_cnt), .code_o(ssel_code),
        .saved_o(saved_cnt_o)
    );

    always_comb begin
        status_o = '0;
        status_o[POS_SSEL +: 3] = ssel_code;
        status_o[POS_RXACT +: 2] = rx_act;
        status_o[POS_TXACT +: 2] = tx_act;
        for (int b = 0; b < NBUF; b++) begin
            status_o[POS_FRM + b] = err[b].frm;
            status_o[POS_PAR + b] = err[b].par;
            status_o[POS_OVF + b] = err[b].ovf;
        end
    end

    assert_dma_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rst_i |=> (((status_o & RX_MASK) == '0) && (saved_cnt_o == '0)));
    assert_rx_fell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_act[0]) && !$past(rx_load_a_i) && !$past(dma_rst_i)) |-> (rx_ptr == BUF_B));
    assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_req_i && !tx_load_a_i && !tx_load_b_i) |=> ($stable(tx_cnt) && $stable(tx_ptr)));

endmodule

// File: tb/rxdma_stat_tracker_tb.sv
`timescale 1ns/1ps
module rxdma_stat_tracker_tb;
    localparam int CNT_W = 8;
    localparam int NV    = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_rst = 0, spi = 0, rla = 0, rlb = 0, rvld = 0, fe = 0, pe = 0, ov = 0;
    logic ssel_n = 1'b1, tla = 0, tlb = 0, treq = 0;
    logic [CNT_W-1:0] rlen = '0, tlen = '0;
    logic rx_pop, tx_pop;
    logic [15:0] status;
    logic [CNT_W-1:0] saved;
    int errs = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rxdma_stat_tracker #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dma_rst_i(dma_rst), .spi_mode_i(spi),
        .rx_load_a_i(rla), .rx_load_b_i(rlb), .rx_len_i(rlen),
        .rx_valid_i(rvld), .rx_frm_err_i(fe), .rx_par_err_i(pe), .rx_ovr_i(ov),
        .rx_pop_o(rx_pop), .ssel_n_i(ssel_n),
        .tx_load_a_i(tla), .tx_load_b_i(tlb), .tx_len_i(tlen), .tx_req_i(treq),
        .tx_pop_o(tx_pop), .status_o(status), .saved_cnt_o(saved)
    );

    // fields: ld_a ld_b len[8] | vld fe pe ov spi ssel_n drst | pop | saved[8] | status[16]
    // status layout (R2): [2:0] code [3]rxA [4]rxB [5]txA [6]txB [7]frmA [8]frmB [9]parA [10]parB [11]ovfA [12]ovfB
    localparam logic [41:0] VEC [NV] = '{
        {2'b00, 8'd0, 7'b0000010, 1'b0, 8'd0, 16'h0000}, // 0 idle
        {2'b10, 8'd2, 7'b0000010, 1'b0, 8'd0, 16'h0008}, // 1 load A  R3
        {2'b01, 8'd2, 7'b0000010, 1'b0, 8'd0, 16'h0018}, // 2 load B  R3
        {2'b00, 8'd0, 7'b1100010, 1'b1, 8'd0, 16'h0098}, // 3 frame into A  R4
        {2'b00, 8'd0, 7'b1010010, 1'b1, 8'd0, 16'h0290}, // 4 parity into A, A done  R5
        {2'b00, 8'd0, 7'b1001010, 1'b1, 8'd0, 16'h1290}, // 5 overrun into B  R6
        {2'b00, 8'd0, 7'b1100010, 1'b1, 8'd0, 16'h1380}, // 6 frame into B, B done  R4
        {2'b00, 8'd0, 7'b1000010, 1'b0, 8'd0, 16'h1380}, // 7 none loaded  R3
        {2'b00, 8'd0, 7'b1001010, 1'b0, 8'd0, 16'h1380}, // 8 overrun, nothing loaded  R6
        {2'b10, 8'd2, 7'b1001010, 1'b0, 8'd0, 16'h1108}, // 9 reload A clears only A  R7
        {2'b00, 8'd0, 7'b1001010, 1'b1, 8'd0, 16'h1908}, // 10 overrun charged to A  R6
        {2'b00, 8'd0, 7'b0000011, 1'b0, 8'd0, 16'h0000}, // 11 dma reset  R8
        {2'b10, 8'd2, 7'b0000110, 1'b0, 8'd0, 16'h0008}, // 12 spi, load A
        {2'b00, 8'd0, 7'b1110110, 1'b1, 8'd0, 16'h0008}, // 13 tags ignored  R9
        {2'b00, 8'd0, 7'b0000100, 1'b0, 8'd0, 16'h0008}, // 14 ssel low
        {2'b00, 8'd0, 7'b0000110, 1'b0, 8'd1, 16'h000A}, // 15 first rise, A  R10
        {2'b00, 8'd0, 7'b0000100, 1'b0, 8'd1, 16'h000A}, // 16 ssel low
        {2'b00, 8'd0, 7'b1000110, 1'b1, 8'd1, 16'h0006}, // 17 second rise  R11
        {2'b01, 8'd2, 7'b0000110, 1'b0, 8'd1, 16'h0010}, // 18 load clears code  R12
        {2'b00, 8'd0, 7'b0000100, 1'b0, 8'd1, 16'h0010}, // 19 ssel low
        {2'b00, 8'd0, 7'b0000110, 1'b0, 8'd0, 16'h0013}, // 20 first rise, B  R10
        {2'b00, 8'd0, 7'b0000000, 1'b0, 8'd0, 16'h0013}, // 21 uart, ssel low
        {2'b00, 8'd0, 7'b0000010, 1'b0, 8'd0, 16'h0013}, // 22 uart rise ignored  R12
        {2'b00, 8'd0, 7'b0000011, 1'b0, 8'd0, 16'h0000}  // 23 dma reset  R8
    };

    function automatic string vreq(int i);
        case (i)
            1, 2, 7:  return "R3";
            3, 6:     return "R4";
            4:        return "R5";
            5, 8, 10: return "R6";
            9:        return "R7";
            11, 23:   return "R8";
            13:       return "R9";
            15, 20:   return "R10";
            17:       return "R11";
            18, 22:   return "R12";
            default:  return "R2";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rla = 0; rlb = 0; rvld = 0; fe = 0; pe = 0; ov = 0; dma_rst = 0;
        tla = 0; tlb = 0; treq = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "status at reset", 32'(status), 32'h0);
        chk("R1", "saved at reset", 32'(saved), 32'h0);
        chk("R1", "pops at reset", {30'd0, rx_pop, tx_pop}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {rla, rlb, rlen, rvld, fe, pe, ov, spi, ssel_n, dma_rst} = VEC[i][41:25];
            #1;
            chk(vreq(i), $sformatf("vec %0d rx_pop", i), 32'(rx_pop), 32'(VEC[i][24]));
            @(posedge clk); #1;
            chk(vreq(i), $sformatf("vec %0d status", i), 32'(status), 32'(VEC[i][15:0]));
            chk(vreq(i), $sformatf("vec %0d saved", i), 32'(saved), 32'(VEC[i][23:16]));
            @(negedge clk);
        end
        idle_inputs();

        // R3 load with zero length stays inactive
        rla = 1; rlen = 8'd0;
        @(posedge clk); #1;
        chk("R3", "zero-length load", 32'(status), 32'h0);
        @(negedge clk); idle_inputs();

        // R13 transmit alternation: A len 1, B len 2
        tla = 1; tlb = 1; tlen = 8'd1;
        @(posedge clk); #1;
        @(negedge clk); tla = 0; tlb = 1; tlen = 8'd2;
        @(posedge clk); #1;
        chk("R13", "tx both active", 32'(status), 32'h60);
        @(negedge clk); idle_inputs(); treq = 1;
        #1 chk("R13", "tx pop A", 32'(tx_pop), 32'h1);
        @(posedge clk); #1;
        chk("R13", "tx A done", 32'(status), 32'h40);
        @(negedge clk); #1;
        chk("R13", "tx pop B1", 32'(tx_pop), 32'h1);
        @(posedge clk); #1;
        chk("R13", "tx B half", 32'(status), 32'h40);
        @(negedge clk);
        @(posedge clk); #1;
        chk("R13", "tx B done", 32'(status), 32'h0);
        @(negedge clk); #1;
        chk("R13", "tx no pop when idle", 32'(tx_pop), 32'h0);
        idle_inputs();

        // R8 dma reset leaves transmit bits alone
        @(negedge clk); tla = 1; tlen = 8'd3;
        @(negedge clk); tla = 0; dma_rst = 1;
        @(posedge clk); #1;
        chk("R8", "tx kept across dma reset", 32'(status), 32'h20);
        @(negedge clk); idle_inputs();

        // R1 mid-run reset
        rla = 1; rlen = 8'd4;
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        #1 chk("R1", "status after async reset", 32'(status), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule